// File: doc/BRIEF.md
# Nearest-Neighbour Line Scaler

The block resizes a raster image independently along each axis, taking every output pixel as a copy of the source pixel nearest to its mapped position. Source pixels arrive one line at a time and are written into one of two line stores. Output pixels are then produced row by row. A horizontal and a vertical output counter are mapped back to source coordinates through unsigned fixed-point scale factors.

The upstream source is paced line by line. After a frame start it sends the first two source lines unprompted. After that it waits for the line-done pulse, reads the requested-line output, and sends that line if it has not sent it yet. When the image shrinks vertically, the requested index jumps past source lines the scaler never uses, so those lines are never transferred. A downstream line-ready input gates the emission of output pixels.

Top module: `nnScaler`

## Requirements
- R1: After reset, `pixOutValid`, `lineDone` and `nextSrcLine` are all zero.
- R2: After `frameStart`, no output pixel appears until two complete source lines have been accepted. `nextSrcLine` reads 0 before the first line and 1 once the first line is complete.
- R3: Output pixel h of a row equals source pixel min(floor(h*scaleH/256), inWidth-1) of the row's source line. The scale inputs are unsigned with 8 fractional bits.
- R4: Output row v is taken from source line min(floor(v*scaleV/256), inHeight-1).
- R5: Each output row has exactly `outWidth` valid pixels. `lineDone` is high for a single cycle, and that cycle is the one carrying the last valid pixel of the row.
- R6: In the `lineDone` cycle, `nextSrcLine` holds the source line of the next output row, or 0 after the last row of the frame. When that line is already held, the scaler continues without new input.
- R7: Input pixels presented while the scaler is not loading a line are ignored and do not alter any later output.
- R8: A valid output pixel appears only in a cycle whose preceding cycle had `lineReady` high. A row does not start while `lineReady` is low.
- R9: After the last row of a frame, no output appears until the next `frameStart`. The next frame starts again at output row 0.
- R10: A pixel word is CHAN_BITS*CHANNELS bits wide and is carried from input to output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Single-cycle pulse that opens a new frame |
| pixIn | input | CHAN_BITS*CHANNELS | Source pixel word |
| pixInValid | input | 1 | Qualifies `pixIn` |
| scaleH | input | SCALE_W | Horizontal factor, source width / output width, 8 fractional bits |
| scaleV | input | SCALE_W | Vertical factor, source height / output height, 8 fractional bits |
| inWidth | input | DIM_W | Source line length in pixels |
| inHeight | input | DIM_W | Source line count |
| outWidth | input | DIM_W | Output line length in pixels |
| outHeight | input | DIM_W | Output line count |
| lineReady | input | 1 | Downstream permits output pixels |
| lineDone | output | 1 | One-cycle pulse with the last pixel of an output row |
| nextSrcLine | output | DIM_W | Index of the source line wanted next |
| pixOut | output | CHAN_BITS*CHANNELS | Scaled pixel word |
| pixOutValid | output | 1 | Qualifies `pixOut` |

## Verification
Every pixel of whole frames is compared against coordinates computed in the bench, over five geometries:
- Identity size separates a mapping error from a buffering error.
- Upscaling in both axes exercises rows that reuse a held line, where no new line is requested.
- Downscaling in both axes exercises line skipping and ping-pong eviction.
- A mixed case and a maximum-width case exercise clipping of the mapped coordinate and the buffer depth limit.

Some frames toggle `lineReady` and insert gaps into the input valid. Some frames push spurious input words while the scaler is not loading, to show they leave the output untouched. A quiet idle stretch after each frame confirms that output stops until the next frame start.

// File: rtl/nnsc_pkg.sv
package nnsc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_WAIT = 2'd2,
    ST_OUT  = 2'd3
  } scState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic wrSel;
    logic rdEn;
    logic rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/nnsc_ctrl.sv
module nnsc_ctrl
  import nnsc_pkg::*;
#(
  parameter int DIM_W   = 8,
  parameter int SCALE_W = 16,
  parameter int FRAC_W  = 8,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic               pixInValid,
  input  logic [SCALE_W-1:0] scaleH,
  input  logic [SCALE_W-1:0] scaleV,
  input  logic [DIM_W-1:0]   inWidth,
  input  logic [DIM_W-1:0]   inHeight,
  input  logic [DIM_W-1:0]   outWidth,
  input  logic [DIM_W-1:0]   outHeight,
  input  logic               lineReady,
  output ctrlStrobe_t        strobe,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic               lineDone,
  output logic [DIM_W-1:0]   nextSrcLine
);

  localparam int PROD_W = DIM_W + SCALE_W;

  // output counter -> clipped source coordinate
  function automatic logic [DIM_W-1:0] srcCoord(input logic [DIM_W-1:0] cnt,
                                                input logic [SCALE_W-1:0] scale,
                                                input logic [DIM_W-1:0] lim);
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] whole;
    prod  = PROD_W'(cnt) * PROD_W'(scale);
    whole = prod >> FRAC_W;
    if (whole >= PROD_W'(lim)) return lim - DIM_W'(1);
    return DIM_W'(whole);
  endfunction

  scState_t         state;
  logic             filling;
  logic             loadSel;
  logic [DIM_W-1:0] loadTag;
  logic [DIM_W-1:0] wrCol;
  logic [DIM_W-1:0] tag [2];
  logic [1:0]       tagValid;
  logic [DIM_W-1:0] vCnt;
  logic [DIM_W-1:0] hCnt;
  logic [DIM_W-1:0] reqLine;
  logic             doneReg;

  logic [DIM_W-1:0] curSy;
  logic [DIM_W-1:0] nextV;
  logic [DIM_W-1:0] nxtSy;
  logic [DIM_W-1:0] sx;
  logic             useSel;
  logic             nextHit;
  logic             wrStrobe;
  logic             lineEnd;
  logic             rdStrobe;
  logic             lastRead;
  logic             frameEnd;

  always_comb begin
    curSy    = srcCoord(vCnt, scaleV, inHeight);
    nextV    = vCnt + DIM_W'(1);
    nxtSy    = srcCoord(nextV, scaleV, inHeight);
    sx       = srcCoord(hCnt, scaleH, inWidth);
    useSel   = tagValid[1] && (tag[1] == curSy);
    nextHit  = (tagValid[0] && (tag[0] == nxtSy)) ||
               (tagValid[1] && (tag[1] == nxtSy));
    wrStrobe = (state == ST_LOAD) && pixInValid && !frameStart;
    lineEnd  = wrStrobe && (wrCol == inWidth - DIM_W'(1));
    rdStrobe = (state == ST_OUT) && lineReady && !frameStart;
    lastRead = rdStrobe && (hCnt == outWidth - DIM_W'(1));
    frameEnd = (nextV == outHeight);
  end

  always_comb begin
    strobe.wrEn  = wrStrobe;
    strobe.wrSel = loadSel;
    strobe.rdEn  = rdStrobe;
    strobe.rdSel = useSel;
    wrAddr       = wrCol[ADDR_W-1:0];
    rdAddr       = sx[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      filling  <= 1'b0;
      loadSel  <= 1'b0;
      loadTag  <= '0;
      wrCol    <= '0;
      tag[0]   <= '0;
      tag[1]   <= '0;
      tagValid <= '0;
      vCnt     <= '0;
      hCnt     <= '0;
      reqLine  <= '0;
      doneReg  <= 1'b0;
    end else if (frameStart) begin
      state    <= ST_LOAD;
      filling  <= 1'b1;
      loadSel  <= 1'b0;
      loadTag  <= '0;
      wrCol    <= '0;
      tagValid <= '0;
      vCnt     <= '0;
      hCnt     <= '0;
      reqLine  <= '0;
      doneReg  <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (state)
        ST_LOAD: begin
          if (wrStrobe) wrCol <= lineEnd ? '0 : wrCol + DIM_W'(1);
          if (lineEnd) begin
            tag[loadSel]      <= loadTag;
            tagValid[loadSel] <= 1'b1;
            if (filling && !loadSel) begin
              loadSel <= 1'b1;
              loadTag <= DIM_W'(1);
              reqLine <= DIM_W'(1);
            end else begin
              filling <= 1'b0;
              state   <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (lineReady) state <= ST_OUT;
        end
        ST_OUT: begin
          if (lastRead) begin
            hCnt    <= '0;
            doneReg <= 1'b1;
            if (frameEnd) begin
              vCnt    <= '0;
              reqLine <= '0;
              state   <= ST_IDLE;
            end else begin
              vCnt    <= nextV;
              reqLine <= nxtSy;
              if (nextHit) begin
                state <= ST_WAIT;
              end else begin
                loadSel <= ~useSel;
                loadTag <= nxtSy;
                state   <= ST_LOAD;
              end
            end
          end else if (rdStrobe) begin
            hCnt <= hCnt + DIM_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign lineDone    = doneReg;
  assign nextSrcLine = reqLine;

endmodule

// File: rtl/nnsc_datapath.sv
module nnsc_datapath
  import nnsc_pkg::*;
#(
  parameter int PIX_W  = 16,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [PIX_W-1:0]  pixIn,
  output logic [PIX_W-1:0]  pixOut,
  output logic              pixOutValid
);

  logic [PIX_W-1:0] rdWord [2];

  for (genvar b = 0; b < 2; b++) begin : g_line
    logic [PIX_W-1:0] store [DEPTH];
    always_ff @(posedge clk) begin
      if (strobe.wrEn && (strobe.wrSel == 1'(b))) store[wrAddr] <= pixIn;
    end
    assign rdWord[b] = store[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOut      <= '0;
      pixOutValid <= 1'b0;
    end else begin
      pixOutValid <= strobe.rdEn;
      if (strobe.rdEn) pixOut <= rdWord[strobe.rdSel];
    end
  end

endmodule

// File: rtl/nnScaler.sv
module nnScaler
  import nnsc_pkg::*;
#(
  parameter int CHAN_BITS = 8,
  parameter int CHANNELS  = 2,
  parameter int MAX_WIDTH = 32,
  parameter int DIM_W     = 8,
  parameter int SCALE_W   = 16,
  parameter int FRAC_W    = 8,
  localparam int PIX_W    = CHAN_BITS * CHANNELS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic [PIX_W-1:0]   pixIn,
  input  logic               pixInValid,
  input  logic [SCALE_W-1:0] scaleH,
  input  logic [SCALE_W-1:0] scaleV,
  input  logic [DIM_W-1:0]   inWidth,
  input  logic [DIM_W-1:0]   inHeight,
  input  logic [DIM_W-1:0]   outWidth,
  input  logic [DIM_W-1:0]   outHeight,
  input  logic               lineReady,
  output logic               lineDone,
  output logic [DIM_W-1:0]   nextSrcLine,
  output logic [PIX_W-1:0]   pixOut,
  output logic               pixOutValid
);

  localparam int ADDR_W = (MAX_WIDTH > 1) ? $clog2(MAX_WIDTH) : 1;

  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  nnsc_ctrl #(
    .DIM_W(DIM_W), .SCALE_W(SCALE_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)
  ) iCtrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .pixInValid(pixInValid),
    .scaleH(scaleH), .scaleV(scaleV), .inWidth(inWidth), .inHeight(inHeight),
    .outWidth(outWidth), .outHeight(outHeight), .lineReady(lineReady),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .lineDone(lineDone), .nextSrcLine(nextSrcLine)
  );

  nnsc_datapath #(
    .PIX_W(PIX_W), .DEPTH(MAX_WIDTH), .ADDR_W(ADDR_W)
  ) iData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .pixIn(pixIn), .pixOut(pixOut), .pixOutValid(pixOutValid)
  );

endmodule

// File: rtl/nnsc_chk.sv
module nnsc_chk (
  input logic clk,
  input logic rstN,
  input logic frameStart,
  input logic lineReady,
  input logic lineDone,
  input logic pixOutValid
);

  // R5
  lineDone_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |=> !lineDone);

  // R5
  lineDone_with_pixel_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |-> pixOutValid);

  // R8
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixOutValid |-> $past(lineReady));

  // R2
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (!pixOutValid && !lineDone));

endmodule

bind nnScaler nnsc_chk u_nnscChk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineReady(lineReady),
  .lineDone(lineDone), .pixOutValid(pixOutValid)
);

// File: tb/test_nnScaler.sv
module test_nnScaler;

  localparam int PIX_W = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic [15:0] pixIn = '0;
  logic        pixInValid = 1'b0;
  logic [15:0] scaleH = '0;
  logic [15:0] scaleV = '0;
  logic [7:0]  inWidth = '0;
  logic [7:0]  inHeight = '0;
  logic [7:0]  outWidth = '0;
  logic [7:0]  outHeight = '0;
  logic        lineReady = 1'b0;
  logic        lineDone;
  logic [7:0]  nextSrcLine;
  logic [15:0] pixOut;
  logic        pixOutValid;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;

  nnScaler i_nnScaler (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .pixIn(pixIn),
    .pixInValid(pixInValid), .scaleH(scaleH), .scaleV(scaleV),
    .inWidth(inWidth), .inHeight(inHeight), .outWidth(outWidth),
    .outHeight(outHeight), .lineReady(lineReady), .lineDone(lineDone),
    .nextSrcLine(nextSrcLine), .pixOut(pixOut), .pixOutValid(pixOutValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pixVal(input int r, input int c);
    return {8'(r * 17 + 3), 8'(c * 9 + r + 1)};
  endfunction

  function automatic int mapCoord(input int cnt, input int scale, input int lim);
    int q;
    q = (cnt * scale) >> 8;
    return (q >= lim) ? lim - 1 : q;
  endfunction

  // mode bit0: toggle lineReady and input gaps; garbage: spurious input words
  task automatic runFrame(input int iw, input int ih, input int ow, input int oh,
                          input bit toggle, input bit garbage);
    int sc_h, sc_v, sRow, sCol, lastSent, loaded, outRow, outCol, cyc;
    bit sending, prevReady;
    sc_h = (iw * 256) / ow;
    sc_v = (ih * 256) / oh;
    scaleH = 16'(sc_h); scaleV = 16'(sc_v);
    inWidth = 8'(iw); inHeight = 8'(ih); outWidth = 8'(ow); outHeight = 8'(oh);
    @(negedge clk);
    frameStart = 1'b1; pixInValid = 1'b0; lineReady = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    // R2: nothing loaded yet, line 0 requested
    check(nextSrcLine == 8'd0, "R2 first request", nextSrcLine, 0);
    sending = 1; sRow = 0; sCol = 0; lastSent = -1; loaded = 0;
    outRow = 0; outCol = 0; cyc = 0;
    while (outRow < oh && cyc < 6000) begin
      lineReady = toggle ? (cyc % 3 != 1) : 1'b1;
      if (sending) begin
        pixInValid = toggle ? (cyc % 4 != 2) : 1'b1;
        pixIn = pixVal(sRow, sCol);
      end else begin
        pixInValid = garbage;
        pixIn = 16'hA5A5;
      end
      @(posedge clk);
      prevReady = lineReady;
      if (sending && pixInValid) begin
        sCol++;
        if (sCol == iw) begin
          sCol = 0; lastSent = sRow; loaded++; sending = 0;
          if (loaded == 1) begin sending = 1; sRow = 1; end
        end
      end
      @(negedge clk);
      if (loaded == 1 && sRow == 1 && sCol == 0 && sending)
        check(nextSrcLine == 8'd1, "R2 second request", nextSrcLine, 1);
      if (loaded < 2)
        check(!pixOutValid, "R2 no output before two lines", pixOutValid, 0);
      if (pixOutValid) begin
        int ey, ex;
        ey = mapCoord(outRow, sc_v, ih);
        ex = mapCoord(outCol, sc_h, iw);
        check(pixOut == pixVal(ey, ex), "R3 R4 R10 pixel value", pixOut, pixVal(ey, ex));
        check(prevReady, "R8 pixel needs ready", prevReady, 1);
        if (lineDone) begin
          int en;
          check(outCol == ow - 1, "R5 line length", outCol + 1, ow);
          en = (outRow + 1 < oh) ? mapCoord(outRow + 1, sc_v, ih) : 0;
          check(nextSrcLine == 8'(en), "R6 requested line", nextSrcLine, en);
          outRow++; outCol = 0;
          if (outRow < oh && int'(nextSrcLine) > lastSent) begin
            sending = 1; sRow = nextSrcLine; sCol = 0;
          end
        end else begin
          outCol++;
          check(outCol < ow, "R5 too many pixels", outCol, ow - 1);
        end
      end else begin
        check(!lineDone, "R5 lineDone without pixel", lineDone, 0);
      end
      cyc++;
    end
    check(outRow == oh, "R5 frame rows completed", outRow, oh);
    // R9 idle after frame, R7 spurious input while idle
    lineReady = 1'b1; pixInValid = 1'b1; pixIn = 16'h5A5A;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(!pixOutValid && !lineDone, "R9 idle after frame", pixOutValid, 0);
    end
    check(nextSrcLine == 8'd0, "R9 request back at row 0", nextSrcLine, 0);
    pixInValid = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    testsFailed++;
    testsRun++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset values
    check(!pixOutValid, "R1 valid at reset", pixOutValid, 0);
    check(!lineDone, "R1 lineDone at reset", lineDone, 0);
    check(nextSrcLine == 8'd0, "R1 request at reset", nextSrcLine, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!pixOutValid && !lineDone, "R1 quiet after reset", pixOutValid, 0);
    runFrame(8, 6, 8, 6, 1'b0, 1'b0);    // identity
    runFrame(5, 3, 12, 7, 1'b1, 1'b1);   // upscale, R7 garbage
    runFrame(16, 12, 6, 4, 1'b0, 1'b1);  // downscale, line skipping R6
    runFrame(20, 4, 7, 9, 1'b1, 1'b0);   // mixed
    runFrame(32, 8, 3, 2, 1'b1, 1'b1);   // full width
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule